// File: doc/BRIEF.md
# PLL Operating-Mode Controller with Acquisition Bandwidth Boost

This block is the mode sequencer for one digitally controlled PLL channel. It watches four qualifiers from the rest of the channel: initialization complete, reference input valid, phase lock detected, and frequency history valid. From these it keeps the channel in one of four operating modes: free-run, acquiring, locked, or holdover. It also picks the loop-bandwidth code that the loop filter uses in each mode.

While the channel is acquiring lock and the boost enable is set, the block sends a separate, wider bandwidth code to the loop filter so that the loop settles sooner. When lock is confirmed, it switches back to the normal code by itself. The boost code cannot go below a floor code, which stands for the narrowest setting the boost range allows. The normal code covers the full range.

A lock is confirmed only after the lock-detect flag has been high for a programmable run of consecutive cycles. When the input is lost, the channel enters holdover only if a usable frequency history exists. Without one it drops to free-run. Each channel is a separate instance.

Top module: `pll_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the mode at free-run. Mode encoding: 2'b00 free-run, 2'b01 acquiring, 2'b10 locked, 2'b11 holdover. After reset `locked_o` and `mode_chg_o` are low.
- R2: While `init_done_i` is low, the mode is free-run at every clock edge, whatever the other inputs are.
- R3: In free-run, with `init_done_i` high and `in_valid_i` high at a clock edge, the mode becomes acquiring.
- R4: In acquiring, the mode becomes locked at the edge that ends the Nth consecutive cycle of acquiring with `lock_det_i` high, where N = `lock_cycles_i`. A value of 0 acts as 1. One low cycle of `lock_det_i` restarts the count.
- R5: In acquiring, `in_valid_i` low at an edge returns the mode to free-run.
- R6: In locked, `in_valid_i` low at an edge moves the mode to holdover if `hist_valid_i` is high, and to free-run otherwise.
- R7: In holdover, `in_valid_i` high at an edge moves the mode to acquiring.
- R8: In acquiring with `fast_en_i` high, `bw_o` equals `bw_fast_i` raised to at least `FL_MIN_CODE`. This output is combinational from the current mode and the code inputs.
- R9: In every other case, `bw_o` equals `bw_norm_i`. This includes locked, holdover, free-run, and any mode with `fast_en_i` low, so the bandwidth reverts with no software action once the channel is locked.
- R10: `mode_chg_o` is high for exactly the first cycle after the mode changes and is low otherwise. `locked_o` is high exactly when the mode is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Channel initialization complete |
| in_valid_i | input | 1 | Reference input present and valid |
| lock_det_i | input | 1 | Phase lock detector output |
| hist_valid_i | input | 1 | Frequency history usable for holdover |
| bw_norm_i | input | BW_W | Normal loop-bandwidth code |
| bw_fast_i | input | BW_W | Acquisition boost bandwidth code |
| fast_en_i | input | 1 | Enable for the acquisition boost |
| lock_cycles_i | input | CNT_W | Consecutive lock-detect cycles required |
| mode_o | output | 2 | Current mode encoding |
| bw_o | output | BW_W | Active bandwidth code to the loop filter |
| locked_o | output | 1 | Mode is locked |
| mode_chg_o | output | 1 | One-cycle pulse after any mode change |

## Verification
The hardest case to reach is a lock-detect run that breaks one cycle short of the threshold. Reaching it means entering acquiring first, then holding `lock_det_i` high for exactly N-1 qualified cycles before a single low cycle. The bench steps edge by edge from the moment acquiring is entered. It then shows that a full N further cycles are needed. Holdover re-entry is reached by locking first and then dropping the input with history valid. This puts the channel back into acquiring through holdover rather than free-run, and the bench confirms the boost code is applied again there.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
   typedef enum logic [1:0] {
      MODE_FREE = 2'b00,
      MODE_ACQ  = 2'b01,
      MODE_LOCK = 2'b10,
      MODE_HOLD = 2'b11
   } pll_mode_e;
endpackage

// File: rtl/pll_lock_qual.sv
// Counts consecutive lock-detect cycles while acquiring; flags the edge
// at which the programmed run length is reached.
module pll_lock_qual #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             active_i,
   input  logic             lock_det_i,
   input  logic [CNT_W-1:0] lock_cycles_i,
   output logic             qual_o
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] run_q;
   logic [EXT_W-1:0] target;
   logic [EXT_W-1:0] run_next_ext;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("pll_lock_qual: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      target       = (lock_cycles_i == '0) ? EXT_W'(1) : {1'b0, lock_cycles_i};
      run_next_ext = {1'b0, run_q} + EXT_W'(1);
      qual_o       = active_i && lock_det_i && (run_next_ext >= target);
   end

   always_ff @(posedge clk) begin
      if (rst || !active_i || !lock_det_i) begin
         run_q <= '0;
      end else if (run_q != {CNT_W{1'b1}}) begin
         run_q <= run_q + CNT_W'(1);
      end
   end

   // a qualified lock with a run longer than one needs lock seen last cycle
   AST_QUAL_RUN: assert property (@(posedge clk) disable iff (rst)
      (qual_o && lock_cycles_i > CNT_W'(1)) |-> $past(lock_det_i)); // R4
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
   import pll_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      init_done_i,
   input  logic      in_valid_i,
   input  logic      hist_valid_i,
   input  logic      qual_i,
   output pll_mode_e mode_o,
   output logic      mode_chg_o
);
   pll_mode_e mode_q, mode_d;
   logic      chg_q;

   always_comb begin
      mode_d = mode_q;
      if (!init_done_i) begin
         mode_d = MODE_FREE;
      end else begin
         unique case (mode_q)
            MODE_FREE: if (in_valid_i) mode_d = MODE_ACQ;
            MODE_ACQ: begin
               if (!in_valid_i)  mode_d = MODE_FREE;
               else if (qual_i)  mode_d = MODE_LOCK;
            end
            MODE_LOCK: begin
               if (!in_valid_i) mode_d = hist_valid_i ? MODE_HOLD : MODE_FREE;
            end
            MODE_HOLD: if (in_valid_i) mode_d = MODE_ACQ;
            default: mode_d = MODE_FREE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_FREE;
         chg_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         chg_q  <= (mode_d != mode_q);
      end
   end

   assign mode_o     = mode_q;
   assign mode_chg_o = chg_q;

   AST_INIT_FREE: assert property (@(posedge clk) disable iff (rst)
      !init_done_i |=> (mode_q == MODE_FREE)); // R2
   AST_ACQ_DROP: assert property (@(posedge clk) disable iff (rst)
      (init_done_i && mode_q == MODE_ACQ && !in_valid_i) |=> (mode_q == MODE_FREE)); // R5
   AST_HOLD_GATE: assert property (@(posedge clk) disable iff (rst)
      (init_done_i && mode_q == MODE_LOCK && !in_valid_i && !hist_valid_i) |=> (mode_q == MODE_FREE)); // R6
   AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (init_done_i && mode_q == MODE_LOCK && !in_valid_i && hist_valid_i) |=> (mode_q == MODE_HOLD)); // R6
   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
      (init_done_i && mode_q == MODE_HOLD && in_valid_i) |=> (mode_q == MODE_ACQ)); // R7
endmodule

// File: rtl/pll_bw_select.sv
module pll_bw_select
   import pll_mode_pkg::*;
#(
   parameter int BW_W        = 5,
   parameter int FL_MIN_CODE = 12,
   parameter bit CLAMP_EN    = 1'b1
) (
   input  pll_mode_e       mode_i,
   input  logic            fast_en_i,
   input  logic [BW_W-1:0] bw_norm_i,
   input  logic [BW_W-1:0] bw_fast_i,
   output logic [BW_W-1:0] bw_o
);
   localparam logic [BW_W-1:0] FLOOR = BW_W'(FL_MIN_CODE);

   logic [BW_W-1:0] fast_eff;

   generate
      if (FL_MIN_CODE < 0 || FL_MIN_CODE >= (1 << BW_W)) begin : g_bad_floor
         $error("pll_bw_select: FL_MIN_CODE does not fit in BW_W bits");
      end
      if (CLAMP_EN) begin : g_clamp
         assign fast_eff = (bw_fast_i < FLOOR) ? FLOOR : bw_fast_i;
      end else begin : g_pass
         assign fast_eff = bw_fast_i;
      end
   endgenerate

   assign bw_o = (mode_i == MODE_ACQ && fast_en_i) ? fast_eff : bw_norm_i;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
   import pll_mode_pkg::*;
#(
   parameter int BW_W        = 5,
   parameter int FL_MIN_CODE = 12,
   parameter int CNT_W       = 8,
   parameter bit CLAMP_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init_done_i,
   input  logic             in_valid_i,
   input  logic             lock_det_i,
   input  logic             hist_valid_i,
   input  logic [BW_W-1:0]  bw_norm_i,
   input  logic [BW_W-1:0]  bw_fast_i,
   input  logic             fast_en_i,
   input  logic [CNT_W-1:0] lock_cycles_i,
   output logic [1:0]       mode_o,
   output logic [BW_W-1:0]  bw_o,
   output logic             locked_o,
   output logic             mode_chg_o
);
   pll_mode_e mode;
   logic      qual;

   generate
      if (BW_W < 1) begin : g_bad_bw
         $error("pll_mode_ctrl: BW_W must be at least 1");
      end
   endgenerate

   pll_lock_qual #(.CNT_W(CNT_W)) qual_i (
      .clk          (clk),
      .rst          (rst),
      .active_i     (mode == MODE_ACQ),
      .lock_det_i   (lock_det_i),
      .lock_cycles_i(lock_cycles_i),
      .qual_o       (qual)
   );

   pll_mode_fsm fsm_i (
      .clk         (clk),
      .rst         (rst),
      .init_done_i (init_done_i),
      .in_valid_i  (in_valid_i),
      .hist_valid_i(hist_valid_i),
      .qual_i      (qual),
      .mode_o      (mode),
      .mode_chg_o  (mode_chg_o)
   );

   pll_bw_select #(
      .BW_W       (BW_W),
      .FL_MIN_CODE(FL_MIN_CODE),
      .CLAMP_EN   (CLAMP_EN)
   ) bw_i (
      .mode_i   (mode),
      .fast_en_i(fast_en_i),
      .bw_norm_i(bw_norm_i),
      .bw_fast_i(bw_fast_i),
      .bw_o     (bw_o)
   );

   assign mode_o   = mode;
   assign locked_o = (mode == MODE_LOCK);

   AST_LOCK_NEEDS_DET: assert property (@(posedge clk) disable iff (rst)
      $rose(locked_o) |-> ($past(lock_det_i) && $past(mode_o) == 2'b01)); // R4
   AST_FREE_TO_ACQ: assert property (@(posedge clk) disable iff (rst)
      (init_done_i && mode_o == 2'b00 && in_valid_i) |=> (mode_o == 2'b01)); // R3
   AST_FAST_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (CLAMP_EN && mode_o == 2'b01 && fast_en_i) |-> (bw_o >= BW_W'(FL_MIN_CODE))); // R8
   AST_NORM_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
      (mode_o != 2'b01 || !fast_en_i) |-> (bw_o == bw_norm_i)); // R9
   AST_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
      mode_chg_o == (mode_o != $past(mode_o))); // R10
endmodule

// File: tb/pll_mode_ctrl_tb_top.sv
module pll_mode_ctrl_tb_top;
   localparam int BW_W  = 5;
   localparam int FLMIN = 12;
   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             init_done = 1'b0, in_valid = 1'b0, lock_det = 1'b0, hist_valid = 1'b0;
   logic [BW_W-1:0]  bw_norm = '0, bw_fast = '0;
   logic             fast_en = 1'b0;
   logic [CNT_W-1:0] lock_cycles = '0;
   logic [1:0]       mode;
   logic [BW_W-1:0]  bw;
   logic             locked, mode_chg;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pll_mode_ctrl #(.BW_W(BW_W), .FL_MIN_CODE(FLMIN), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst(rst), .init_done_i(init_done), .in_valid_i(in_valid),
      .lock_det_i(lock_det), .hist_valid_i(hist_valid), .bw_norm_i(bw_norm),
      .bw_fast_i(bw_fast), .fast_en_i(fast_en), .lock_cycles_i(lock_cycles),
      .mode_o(mode), .bw_o(bw), .locked_o(locked), .mode_chg_o(mode_chg));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick();
      tick();
      rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic int clamp(input int f);
      return (f < FLMIN) ? FLMIN : f;
   endfunction

   // enter locked from reset with run length 1
   task automatic go_locked();
      do_reset();
      init_done = 1'b1; in_valid = 1'b1; lock_det = 1'b1; lock_cycles = 4'd1;
      tick();
      tick();
      chk("R4 setup locked", mode, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 mode after reset", mode, 0);
      chk("R1 locked after reset", locked, 0);
      chk("R1 mode_chg after reset", mode_chg, 0);

      // R2 init low holds free-run
      in_valid = 1'b1; lock_det = 1'b1; lock_cycles = 4'd1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R2 held free while init low", mode, 0);
      end

      // R3 R4 R10 run-length sweep including N=0
      for (int n = 0; n < 7; n++) begin
         int eff;
         eff = (n == 0) ? 1 : n;
         do_reset();
         init_done = 1'b1; in_valid = 1'b1; lock_det = 1'b1; lock_cycles = CNT_W'(n);
         tick();
         chk("R3 free to acquiring", mode, 1);
         chk("R10 pulse on entry to acquiring", mode_chg, 1);
         for (int i = 1; i < eff; i++) begin
            tick();
            chk("R4 still acquiring before run ends", mode, 1);
            chk("R10 no pulse while steady", mode_chg, 0);
         end
         tick();
         chk("R4 locked after run", mode, 2);
         chk("R10 locked flag", locked, 1);
         chk("R10 pulse on lock", mode_chg, 1);
         tick();
         chk("R10 pulse lasts one cycle", mode_chg, 0);
      end

      // R4 gap restarts count (N=4)
      do_reset();
      init_done = 1'b1; in_valid = 1'b1; lock_det = 1'b1; lock_cycles = 4'd4;
      tick();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 pre-gap acquiring", mode, 1);
      end
      lock_det = 1'b0;
      tick();
      chk("R4 gap cycle acquiring", mode, 1);
      lock_det = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 restarted run not yet locked", mode, 1);
      end
      tick();
      chk("R4 locked after fresh full run", mode, 2);

      // R5 loss during acquiring
      do_reset();
      init_done = 1'b1; in_valid = 1'b1; lock_det = 1'b0;
      tick();
      in_valid = 1'b0;
      tick();
      chk("R5 acquiring to free on loss", mode, 0);

      // R6 loss while locked, with and without history
      go_locked();
      in_valid = 1'b0; hist_valid = 1'b1;
      tick();
      chk("R6 locked to holdover with history", mode, 3);
      chk("R10 locked flag low in holdover", locked, 0);
      go_locked();
      in_valid = 1'b0; hist_valid = 1'b0;
      tick();
      chk("R6 locked to free without history", mode, 0);

      // R2 init drop while locked
      go_locked();
      init_done = 1'b0;
      tick();
      chk("R2 init drop forces free", mode, 0);

      // R7 holdover re-acquires and boost applies again
      go_locked();
      in_valid = 1'b0; hist_valid = 1'b1;
      tick();
      in_valid = 1'b1; lock_det = 1'b0; fast_en = 1'b1;
      bw_norm = 5'd3; bw_fast = 5'd20;
      tick();
      chk("R7 holdover to acquiring", mode, 1);
      #1;
      chk("R8 boost on re-acquisition", bw, 20);

      // R8 R9 exhaustive code sweep in acquiring
      for (int e = 0; e < 2; e++) begin
         for (int nb = 0; nb < 32; nb++) begin
            for (int fb = 0; fb < 32; fb++) begin
               fast_en = e[0]; bw_norm = BW_W'(nb); bw_fast = BW_W'(fb);
               #1;
               if (e == 1) chk("R8 clamped boost code", bw, clamp(fb));
               else        chk("R9 normal code with boost off", bw, nb);
            end
         end
      end

      // R9 revert in locked, holdover, free
      fast_en = 1'b1; lock_det = 1'b1; lock_cycles = 4'd1;
      tick();
      chk("R9 locked reached", mode, 2);
      for (int fb = 0; fb < 32; fb++) begin
         bw_norm = 5'd7; bw_fast = BW_W'(fb);
         #1;
         chk("R9 normal code in locked", bw, 7);
      end
      in_valid = 1'b0; hist_valid = 1'b1;
      tick();
      bw_fast = 5'd31; bw_norm = 5'd1;
      #1;
      chk("R9 normal code in holdover", bw, 1);
      init_done = 1'b0;
      tick();
      bw_norm = 5'd0;
      #1;
      chk("R9 normal code in free-run", bw, 0);

      finish_run();
   end
endmodule